// File: doc/BRIEF.md
# Miss-File Store Conflict Tracker

This block guards outstanding load misses against stores that execute while those misses are still in flight. It keeps a small miss file, by default 8 entries. Each entry records the 32-byte block it targets, whether it holds a load, and where it stands in its life cycle. Each entry runs its own state machine. MF_FREE goes to MF_PEND on allocate. MF_PEND goes to MF_ISSUED when the miss is issued to the external bus interface. MF_ISSUED goes back to MF_FREE when its fill returns.

Every executed store compares its block address with all live load entries. A live entry in the same block is poisoned. Its fill will not be written into the data cache, and later loads can no longer merge into it. A matching entry that is still in MF_PEND also sets one bit in the conflict mask of the store's write-buffer slot. The write buffer has 6 slots by default, and each slot runs its own state machine. SB_CLEAR goes to SB_HELD when a store writes a non-empty mask. SB_HELD goes back to SB_CLEAR when the last mask bit clears through a miss issue, or when a new store replaces the mask with an empty one. SB_HELD stays in SB_HELD when the replacement mask is not empty. A slot in SB_CLEAR reports that its store may go to the bus.

Top module: `mfst_tracker`

## Requirements
- R1: After reset all miss entries are free, every bit of `st_may_issue` is 1, `merge_hit` is 0 and `fill_dcache_we` is 0.
- R2: An allocate to a free entry makes it pending in the next cycle, holding the given block and load flag. An allocate to an entry that is not free is ignored.
- R3: Addresses are compared at 32-byte block granularity: bits [4:0] take no part in any comparison. Addresses differing only in bit 5 or above are in different blocks.
- R4: `fill_dcache_we` is 1 in the cycle `fill_valid` names an issued entry that has not been poisoned. It is 0 for a poisoned issued entry.
- R5: `merge_hit` is 1 when a live load entry of the requested block has not been poisoned. `merge_idx` then gives the lowest such entry. Entries allocated with the load flag 0 are never matched by merges or stores.
- R6: A store that matches one or more pending load entries writes a mask with one bit per such entry (bit i = entry i) into slot `st_wb_idx`. In the next cycle, bit `st_wb_idx` of `st_may_issue` is 0.
- R7: Issuing miss entry i clears bit i in every slot mask. A slot's `st_may_issue` bit returns to 1 in the cycle after its last bit clears.
- R8: A store matching an already issued entry poisons it but sets no conflict bit.
- R9: When a store and the issue of a matching entry fall in the same cycle, the issue comes first and that entry gets no conflict bit.
- R10: A fill returning on an issued entry frees it and clears its poison. An entry allocated afterwards can be merged into again.
- R11: A store to a write-buffer slot replaces that slot's previous mask entirely.
- R12: An issue naming an entry that is not pending, and a fill naming an entry that is not issued, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a miss entry |
| alloc_idx | input | 3 | Entry to allocate |
| alloc_addr | input | 32 | Byte address of the miss |
| alloc_load | input | 1 | Entry holds a load (1) or not (0) |
| merge_valid | input | 1 | Load merge lookup request |
| merge_addr | input | 32 | Byte address of the merging load |
| merge_hit | output | 1 | A mergeable entry exists |
| merge_idx | output | 3 | Lowest mergeable entry |
| issue_valid | input | 1 | A miss entry is issued to the bus |
| issue_idx | input | 3 | Entry being issued |
| fill_valid | input | 1 | Fill data returns for an entry |
| fill_idx | input | 3 | Entry whose fill returns |
| fill_dcache_we | output | 1 | Fill may be written into the data cache |
| st_valid | input | 1 | A store executes |
| st_addr | input | 32 | Byte address of the store |
| st_wb_idx | input | 3 | Write-buffer slot of the store |
| st_may_issue | output | 6 | Per slot: store may go to the bus |

## Verification
The assertions check several rules on every cycle. Fill write-enable and merge hits appear only with their requests. A free entry never carries poison. A conflict bit exists only for a pending entry. A miss issue leaves no mask bit for that entry behind. A slot may only turn issuable after a miss issue or a store to that slot. The directed scenarios show what the assertions cannot see on their own: the block-granular compare, the poison and merge outcomes for given addresses, the ordering of a same-cycle store and issue, mask replacement, and which commands are ignored.

// File: rtl/mfst_pkg.sv
package mfst_pkg;

    typedef enum logic [1:0] {
        MF_FREE   = 2'd0,
        MF_PEND   = 2'd1,
        MF_ISSUED = 2'd2
    } miss_st_e;

    typedef enum logic {
        SB_CLEAR = 1'b0,
        SB_HELD  = 1'b1
    } slot_st_e;

endpackage

// File: rtl/mfst_miss_entry.sv
module mfst_miss_entry
    import mfst_pkg::*;
#(
    parameter int BLK_W = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_hit,
    input  logic [BLK_W-1:0] alloc_blk,
    input  logic             alloc_load,
    input  logic             issue_hit,
    input  logic             fill_hit,
    input  logic             st_valid,
    input  logic [BLK_W-1:0] st_blk,
    input  logic             mg_valid,
    input  logic [BLK_W-1:0] mg_blk,
    output miss_st_e         state,
    output logic             nofill,
    output logic             nomerge,
    output logic             conflict,
    output logic             mergeable
);

    miss_st_e         state_q, state_d;
    logic [BLK_W-1:0] blk_q;
    logic             load_q;
    logic             nofill_q, nomerge_q;
    logic             live, poison;

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MF_FREE:   if (alloc_hit) state_d = MF_PEND;
            MF_PEND:   if (issue_hit) state_d = MF_ISSUED;
            MF_ISSUED: if (fill_hit)  state_d = MF_FREE;
            default:   state_d = MF_FREE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MF_FREE;
        else        state_q <= state_d;
    end

    // entry payload and poison flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q     <= '0;
            load_q    <= 1'b0;
            nofill_q  <= 1'b0;
            nomerge_q <= 1'b0;
        end else if (state_q == MF_FREE && alloc_hit) begin
            blk_q     <= alloc_blk;
            load_q    <= alloc_load;
            nofill_q  <= 1'b0;
            nomerge_q <= 1'b0;
        end else if (state_q == MF_ISSUED && fill_hit) begin
            nofill_q  <= 1'b0;
            nomerge_q <= 1'b0;
        end else if (poison) begin
            nofill_q  <= 1'b1;
            nomerge_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        live      = (state_q != MF_FREE);
        poison    = st_valid && live && load_q && (blk_q == st_blk);
        conflict  = poison && (state_q == MF_PEND) && !issue_hit;
        mergeable = mg_valid && live && load_q && !nomerge_q && (blk_q == mg_blk);
        state     = state_q;
        nofill    = nofill_q;
        nomerge   = nomerge_q;
    end

endmodule

// File: rtl/mfst_wb_slot.sv
module mfst_wb_slot
    import mfst_pkg::*;
#(
    parameter int N_MISS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_hit,
    input  logic [N_MISS-1:0] conflict_vec,
    input  logic [N_MISS-1:0] clr_vec,
    output logic [N_MISS-1:0] mask,
    output logic              may_issue
);

    slot_st_e          state_q, state_d;
    logic [N_MISS-1:0] mask_q, mask_d;

    always_comb begin
        mask_d  = st_hit ? conflict_vec : (mask_q & ~clr_vec);
        state_d = state_q;
        unique case (state_q)
            SB_CLEAR: if (st_hit && (|conflict_vec)) state_d = SB_HELD;
            SB_HELD:  if (mask_d == '0)              state_d = SB_CLEAR;
            default:  state_d = SB_CLEAR;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SB_CLEAR;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    // outputs
    always_comb begin
        mask      = mask_q;
        may_issue = (state_q == SB_CLEAR);
    end

endmodule

// File: rtl/mfst_tracker.sv
module mfst_tracker
    import mfst_pkg::*;
#(
    parameter int N_MISS      = 8,
    parameter int N_WB        = 6,
    parameter int ADDR_W      = 32,
    parameter int BLOCK_BYTES = 32,
    localparam int MI_W  = (N_MISS > 1) ? $clog2(N_MISS) : 1,
    localparam int WB_W  = (N_WB > 1) ? $clog2(N_WB) : 1,
    localparam int OFF_W = $clog2(BLOCK_BYTES),
    localparam int BLK_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [MI_W-1:0]   alloc_idx,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic              alloc_load,
    input  logic              merge_valid,
    input  logic [ADDR_W-1:0] merge_addr,
    output logic              merge_hit,
    output logic [MI_W-1:0]   merge_idx,
    input  logic              issue_valid,
    input  logic [MI_W-1:0]   issue_idx,
    input  logic              fill_valid,
    input  logic [MI_W-1:0]   fill_idx,
    output logic              fill_dcache_we,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [WB_W-1:0]   st_wb_idx,
    output logic [N_WB-1:0]   st_may_issue
);

    logic [N_MISS-1:0]      alloc_hit, issue_hit, fill_hit;
    logic [N_MISS-1:0]      ent_free, ent_pend, ent_issued;
    logic [N_MISS-1:0]      ent_nofill, ent_nomerge;
    logic [N_MISS-1:0]      conflict_vec, mergeable, clr_vec;
    logic [N_WB-1:0]        slot_hit;
    logic [N_WB*N_MISS-1:0] wb_mask_flat;
    logic                   unused_lsbs;

    assign unused_lsbs = ^{alloc_addr[OFF_W-1:0], st_addr[OFF_W-1:0], merge_addr[OFF_W-1:0]};

    // command decode per miss entry
    always_comb begin
        for (int i = 0; i < N_MISS; i++) begin
            alloc_hit[i] = alloc_valid && (alloc_idx == MI_W'(i));
            issue_hit[i] = issue_valid && (issue_idx == MI_W'(i));
            fill_hit[i]  = fill_valid  && (fill_idx  == MI_W'(i));
            clr_vec[i]   = issue_hit[i] && ent_pend[i];
        end
        for (int k = 0; k < N_WB; k++) begin
            slot_hit[k] = st_valid && (st_wb_idx == WB_W'(k));
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < N_MISS; gi++) begin : g_ent
            miss_st_e st;
            mfst_miss_entry #(.BLK_W(BLK_W)) u_ent (
                .clk        (clk),
                .rst_n      (rst_n),
                .alloc_hit  (alloc_hit[gi]),
                .alloc_blk  (alloc_addr[ADDR_W-1:OFF_W]),
                .alloc_load (alloc_load),
                .issue_hit  (issue_hit[gi]),
                .fill_hit   (fill_hit[gi]),
                .st_valid   (st_valid),
                .st_blk     (st_addr[ADDR_W-1:OFF_W]),
                .mg_valid   (merge_valid),
                .mg_blk     (merge_addr[ADDR_W-1:OFF_W]),
                .state      (st),
                .nofill     (ent_nofill[gi]),
                .nomerge    (ent_nomerge[gi]),
                .conflict   (conflict_vec[gi]),
                .mergeable  (mergeable[gi])
            );
            assign ent_free[gi]   = (st == MF_FREE);
            assign ent_pend[gi]   = (st == MF_PEND);
            assign ent_issued[gi] = (st == MF_ISSUED);
        end
    endgenerate

    genvar gk;
    generate
        for (gk = 0; gk < N_WB; gk++) begin : g_slot
            mfst_wb_slot #(.N_MISS(N_MISS)) u_slot (
                .clk          (clk),
                .rst_n        (rst_n),
                .st_hit       (slot_hit[gk]),
                .conflict_vec (conflict_vec),
                .clr_vec      (clr_vec),
                .mask         (wb_mask_flat[gk*N_MISS +: N_MISS]),
                .may_issue    (st_may_issue[gk])
            );
        end
    endgenerate

    // lowest mergeable entry wins
    always_comb begin
        merge_hit = 1'b0;
        merge_idx = '0;
        for (int i = N_MISS - 1; i >= 0; i--) begin
            if (mergeable[i]) begin
                merge_hit = 1'b1;
                merge_idx = MI_W'(i);
            end
        end
    end

    assign fill_dcache_we = fill_valid && ent_issued[fill_idx] && !ent_nofill[fill_idx];

endmodule

// File: rtl/mfst_tracker_chk.sv
module mfst_tracker_chk #(
    parameter int N_MISS = 8,
    parameter int N_WB   = 6,
    localparam int MI_W  = (N_MISS > 1) ? $clog2(N_MISS) : 1,
    localparam int WB_W  = (N_WB > 1) ? $clog2(N_WB) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   issue_valid,
    input logic [MI_W-1:0]        issue_idx,
    input logic                   st_valid,
    input logic [WB_W-1:0]        st_wb_idx,
    input logic                   fill_valid,
    input logic                   fill_dcache_we,
    input logic                   merge_valid,
    input logic                   merge_hit,
    input logic [N_WB-1:0]        st_may_issue,
    input logic [N_WB*N_MISS-1:0] wb_mask_flat,
    input logic [N_MISS-1:0]      ent_free,
    input logic [N_MISS-1:0]      ent_pend,
    input logic [N_MISS-1:0]      ent_nofill,
    input logic [N_MISS-1:0]      ent_nomerge
);

    logic [N_MISS-1:0] col;

    always_comb begin
        col = '0;
        for (int k = 0; k < N_WB; k++) col = col | wb_mask_flat[k*N_MISS +: N_MISS];
    end

    p_fill_we_needs_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_dcache_we |-> fill_valid);

    p_merge_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        merge_hit |-> merge_valid);

    genvar gj;
    generate
        for (gj = 0; gj < N_MISS; gj++) begin : g_ent_chk
            p_free_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
                ent_free[gj] |-> (!ent_nofill[gj] && !ent_nomerge[gj]));

            p_mask_from_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
                col[gj] |-> ent_pend[gj]);

            p_issue_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (issue_valid && issue_idx == MI_W'(gj)) |=> !col[gj]);
        end
    endgenerate

    genvar gs;
    generate
        for (gs = 0; gs < N_WB; gs++) begin : g_slot_chk
            p_may_rise_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(st_may_issue[gs]) |->
                    ($past(issue_valid) || $past(st_valid && st_wb_idx == WB_W'(gs))));
        end
    endgenerate

endmodule

bind mfst_tracker mfst_tracker_chk #(.N_MISS(N_MISS), .N_WB(N_WB)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .issue_valid    (issue_valid),
    .issue_idx      (issue_idx),
    .st_valid       (st_valid),
    .st_wb_idx      (st_wb_idx),
    .fill_valid     (fill_valid),
    .fill_dcache_we (fill_dcache_we),
    .merge_valid    (merge_valid),
    .merge_hit      (merge_hit),
    .st_may_issue   (st_may_issue),
    .wb_mask_flat   (wb_mask_flat),
    .ent_free       (ent_free),
    .ent_pend       (ent_pend),
    .ent_nofill     (ent_nofill),
    .ent_nomerge    (ent_nomerge)
);

// File: tb/mfst_tracker_tb.sv
`timescale 1ns/1ps
module mfst_tracker_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        alloc_valid, alloc_load;
    logic [2:0]  alloc_idx;
    logic [31:0] alloc_addr;
    logic        merge_valid;
    logic [31:0] merge_addr;
    logic        merge_hit;
    logic [2:0]  merge_idx;
    logic        issue_valid;
    logic [2:0]  issue_idx;
    logic        fill_valid;
    logic [2:0]  fill_idx;
    logic        fill_dcache_we;
    logic        st_valid;
    logic [31:0] st_addr;
    logic [2:0]  st_wb_idx;
    logic [5:0]  st_may_issue;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    mfst_tracker u_dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_idx(alloc_idx), .alloc_addr(alloc_addr), .alloc_load(alloc_load),
        .merge_valid(merge_valid), .merge_addr(merge_addr), .merge_hit(merge_hit), .merge_idx(merge_idx),
        .issue_valid(issue_valid), .issue_idx(issue_idx),
        .fill_valid(fill_valid), .fill_idx(fill_idx), .fill_dcache_we(fill_dcache_we),
        .st_valid(st_valid), .st_addr(st_addr), .st_wb_idx(st_wb_idx),
        .st_may_issue(st_may_issue)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic idle();
        alloc_valid = 0; alloc_idx = 0; alloc_addr = 0; alloc_load = 0;
        merge_valid = 0; merge_addr = 0;
        issue_valid = 0; issue_idx = 0;
        fill_valid = 0; fill_idx = 0;
        st_valid = 0; st_addr = 0; st_wb_idx = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        idle();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic alloc(input logic [2:0] idx, input logic [31:0] a, input logic ld);
        alloc_valid = 1; alloc_idx = idx; alloc_addr = a; alloc_load = ld;
        step();
        idle();
    endtask

    task automatic issue(input logic [2:0] idx);
        issue_valid = 1; issue_idx = idx;
        step();
        idle();
    endtask

    task automatic store(input logic [31:0] a, input logic [2:0] slot);
        st_valid = 1; st_addr = a; st_wb_idx = slot;
        step();
        idle();
    endtask

    task automatic probe_merge(input logic [31:0] a, input bit exp_hit, input logic [2:0] exp_idx, input string req);
        merge_valid = 1; merge_addr = a;
        #1;
        chk(merge_hit == exp_hit, req, {31'd0, merge_hit}, {31'd0, exp_hit});
        if (exp_hit) chk(merge_idx == exp_idx, req, {29'd0, merge_idx}, {29'd0, exp_idx});
        merge_valid = 0;
    endtask

    task automatic probe_fill(input logic [2:0] idx, input bit exp_we, input bit commit, input string req);
        fill_valid = 1; fill_idx = idx;
        #1;
        chk(fill_dcache_we == exp_we, req, {31'd0, fill_dcache_we}, {31'd0, exp_we});
        if (commit) step();
        idle();
    endtask

    task automatic t_reset();
        do_reset();
        chk(st_may_issue == 6'h3f, "R1 may_issue", {26'd0, st_may_issue}, 32'h3f);
        probe_merge(32'h0, 1'b0, 3'd0, "R1 merge");
        probe_fill(3'd0, 1'b0, 1'b0, "R1 fill_we");
    endtask

    task automatic t_alloc_merge();
        do_reset();
        alloc(3'd0, 32'h1000, 1'b1);
        probe_merge(32'h101F, 1'b1, 3'd0, "R3 same block");
        probe_merge(32'h1020, 1'b0, 3'd0, "R3 next block");
        alloc(3'd0, 32'h2000, 1'b1);
        probe_merge(32'h2000, 1'b0, 3'd0, "R2 busy alloc ignored");
        probe_merge(32'h1000, 1'b1, 3'd0, "R2 original kept");
        alloc(3'd1, 32'h3000, 1'b0);
        probe_merge(32'h3000, 1'b0, 3'd0, "R5 non-load entry");
        alloc(3'd2, 32'h1000, 1'b1);
        probe_merge(32'h1000, 1'b1, 3'd0, "R5 lowest index");
        store(32'h3004, 3'd0);
        chk(st_may_issue == 6'h3f, "R5 store vs non-load", {26'd0, st_may_issue}, 32'h3f);
    endtask

    task automatic t_conflict();
        do_reset();
        alloc(3'd3, 32'h4000, 1'b1);
        alloc(3'd5, 32'h4010, 1'b1);
        store(32'h401C, 3'd2);
        chk(st_may_issue == 6'b111011, "R6 slot held", {26'd0, st_may_issue}, 32'h3b);
        probe_merge(32'h4000, 1'b0, 3'd0, "R5 poisoned no merge");
        issue(3'd3);
        chk(st_may_issue == 6'b111011, "R7 one bit left", {26'd0, st_may_issue}, 32'h3b);
        issue(3'd5);
        chk(st_may_issue == 6'h3f, "R7 all clear", {26'd0, st_may_issue}, 32'h3f);
        probe_fill(3'd3, 1'b0, 1'b1, "R4 poisoned fill");
    endtask

    task automatic t_issued();
        do_reset();
        alloc(3'd1, 32'h5000, 1'b1);
        issue(3'd1);
        store(32'h5008, 3'd0);
        chk(st_may_issue == 6'h3f, "R8 issued no conflict", {26'd0, st_may_issue}, 32'h3f);
        probe_merge(32'h5000, 1'b0, 3'd0, "R8 issued still poisoned");
        probe_fill(3'd1, 1'b0, 1'b1, "R4 fill suppressed");
        alloc(3'd1, 32'h5000, 1'b1);
        probe_merge(32'h5000, 1'b1, 3'd1, "R10 reuse mergeable");
        issue(3'd1);
        probe_fill(3'd1, 1'b1, 1'b1, "R4 clean fill writes");
    endtask

    task automatic t_same_cycle();
        do_reset();
        alloc(3'd4, 32'h6000, 1'b1);
        alloc(3'd6, 32'h6000, 1'b1);
        st_valid = 1; st_addr = 32'h6000; st_wb_idx = 3'd4;
        issue_valid = 1; issue_idx = 3'd4;
        step();
        idle();
        chk(st_may_issue == 6'b101111, "R9 held by other entry", {26'd0, st_may_issue}, 32'h2f);
        issue(3'd6);
        chk(st_may_issue == 6'h3f, "R9 issuing entry not counted", {26'd0, st_may_issue}, 32'h3f);
    endtask

    task automatic t_replace();
        do_reset();
        alloc(3'd0, 32'h7000, 1'b1);
        store(32'h7000, 3'd1);
        chk(st_may_issue == 6'b111101, "R11 first held", {26'd0, st_may_issue}, 32'h3d);
        store(32'h8000, 3'd1);
        chk(st_may_issue == 6'h3f, "R11 mask replaced", {26'd0, st_may_issue}, 32'h3f);
    endtask

    task automatic t_ignore();
        do_reset();
        alloc(3'd2, 32'h9000, 1'b1);
        probe_fill(3'd2, 1'b0, 1'b1, "R12 fill on pending");
        probe_merge(32'h9000, 1'b1, 3'd2, "R12 entry not freed");
        issue(3'd7);
        alloc(3'd7, 32'hA000, 1'b1);
        store(32'hA000, 3'd3);
        chk(st_may_issue == 6'b110111, "R12 issue on free ignored", {26'd0, st_may_issue}, 32'h37);
    endtask

    initial begin
        #40000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 1'b0;
        @(negedge clk);
        t_reset();
        t_alloc_merge();
        t_conflict();
        t_issued();
        t_same_cycle();
        t_replace();
        t_ignore();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule